// File: doc/BRIEF.md
# Supervisory Reset Generator with Watchdog

This block produces the system reset for a microcontroller subsystem. It runs on a slow, always-on reference clock. Three conditions request a reset. The first is a synchronised flag that reports the supply is below its threshold. The second is an active-low manual reset input. The third is a watchdog that expires when software stops toggling a strobe input. The three asynchronous inputs each pass through a two-flop synchroniser. The strobe also passes through a stability filter before its edges count.

All reset requests share one release timer. While any request is active, the timer is held at zero. After the last request goes away, the timer counts a programmable number of cycles and then releases the reset. This makes every reset pulse at least that long. The watchdog counter is held at zero for as long as reset is asserted, and it starts counting only after release. Either edge of a filtered strobe clears it. If the strobe is stuck, the block therefore produces a steady train of reset pulses. The main output is active low. A complementary active-high output can be added by parameter.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While the power-on reset `rst` is high, `rst_n_o` is 0. With all requests inactive, `rst_n_o` goes to 1 exactly REL_CYCLES clock edges after the first edge at which `rst` is low. Every low pulse of `rst_n_o` lasts at least REL_CYCLES cycles.
- R2: `sup_low_i` = 1 drives `rst_n_o` low on the 3rd clock edge after the change. The output stays low while the flag is high. The output rises on the (REL_CYCLES+2)-th edge after the flag returns to 0. A new supply-low event during the release countdown restarts the countdown from zero.
- R3: `man_rst_n_i` = 0 drives `rst_n_o` low on the 3rd clock edge. The output stays low while the input is low. The output rises on the (REL_CYCLES+2)-th edge after the input returns to 1.
- R4: If the strobe shows no accepted edge, `rst_n_o` falls exactly WDT_CYCLES edges after it rose. It then stays low for REL_CYCLES cycles. A stuck strobe therefore gives reset pulses with a period of WDT_CYCLES+REL_CYCLES.
- R5: Both a rising and a falling strobe edge clear the watchdog. A strobe that toggles with a half-period below the timeout keeps reset released, even when the gap between edges of one polarity alone exceeds the timeout.
- R6: A new strobe level counts only if it stays unchanged for at least FILT_CYCLES (default 2) synchronised cycles. Single-cycle strobe pulses do not clear the watchdog.
- R7: The watchdog counter stays cleared while reset is asserted. After any reset, however long, the next timeout comes a full WDT_CYCLES after release.
- R8: When HAS_POS_OUT = 1, `rst_p_o` is always the exact complement of `rst_n_o`. When HAS_POS_OUT = 0, `rst_p_o` is tied to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock |
| rst | input | 1 | Synchronous active-high power-on reset of this clock domain |
| sup_low_i | input | 1 | Supply-below-threshold flag, asynchronous |
| man_rst_n_i | input | 1 | Manual reset request, active low, asynchronous |
| wdt_strobe_i | input | 1 | Watchdog strobe from software, asynchronous |
| rst_n_o | output | 1 | System reset, active low, registered |
| rst_p_o | output | 1 | Complementary active-high reset, or 0 when not built |

## Verification
The bench measures each pulse width exactly, in cycles, so an off-by-one in the release timer or the watchdog terminal count shows up directly. A strobe toggling at 60 cycles against a 100-cycle timeout catches a design that kicks on one edge polarity only, because that design would fire a reset within one strobe period. Single-cycle strobe glitches must leave the watchdog timeout at its full length; a missing filter would stretch that timeout instead. A long manual reset with a stuck strobe, and a second supply-low event during the release countdown, expose a watchdog that counts during reset or a timer that fails to restart. Either fault shortens the pulse that follows.

// File: rtl/sr_pkg.sv
package sr_pkg;
  typedef enum logic {
    REL_OPEN = 1'b0,
    REL_HOLD = 1'b1
  } rel_state_e;

  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[s] <= RST_VAL;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sr_edge_filter.sv
module sr_edge_filter #(
  parameter int FILT_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic kick_o
);
  localparam int CW = sr_pkg::cnt_width(FILT_CYCLES);

  logic          stable_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stable_q <= 1'b0;
      run_q    <= '0;
      kick_o   <= 1'b0;
    end else begin
      kick_o <= 1'b0;
      if (lvl_i == stable_q) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_CYCLES - 1)) begin
        stable_q <= lvl_i;
        run_q    <= '0;
        kick_o   <= 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sr_watchdog.sv
module sr_watchdog #(
  parameter int WDT_CYCLES = 100,
  localparam int WW = sr_pkg::cnt_width(WDT_CYCLES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_i,
  input  logic          kick_i,
  output logic          fire_o,
  output logic [WW-1:0] cnt_o
);
  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || hold_i || kick_i) begin
      cnt_q <= '0;
    end else if (cnt_q != WW'(WDT_CYCLES - 1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign fire_o = !hold_i && !kick_i && (cnt_q == WW'(WDT_CYCLES - 1));
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/sr_release.sv
module sr_release #(
  parameter int REL_CYCLES = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic cause_i,
  output logic hold_o
);
  import sr_pkg::*;
  localparam int RW = cnt_width(REL_CYCLES);

  rel_state_e    state_q;
  logic [RW-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= REL_HOLD;
      tmr_q   <= '0;
    end else if (cause_i) begin
      state_q <= REL_HOLD;
      tmr_q   <= '0;
    end else if (state_q == REL_HOLD) begin
      if (tmr_q == RW'(REL_CYCLES - 1)) begin
        state_q <= REL_OPEN;
        tmr_q   <= '0;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  assign hold_o = (state_q == REL_HOLD);
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int REL_CYCLES  = 6554,
  parameter int WDT_CYCLES  = 52429,
  parameter int FILT_CYCLES = 2,
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_POS_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sup_low_i,
  input  logic man_rst_n_i,
  input  logic wdt_strobe_i,
  output logic rst_n_o,
  output logic rst_p_o
);
  localparam int WW = sr_pkg::cnt_width(WDT_CYCLES);

  logic [2:0]    sync_q;
  logic          sup_low_s;
  logic          man_n_s;
  logic          strobe_s;
  logic          kick;
  logic          wdt_fire;
  logic [WW-1:0] wdt_cnt;
  logic          hold;
  logic          cause;

  sr_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) i_sync (
    .clk(clk),
    .rst(rst),
    .d_i({wdt_strobe_i, man_rst_n_i, sup_low_i}),
    .q_o(sync_q)
  );

  assign sup_low_s = sync_q[0];
  assign man_n_s   = sync_q[1];
  assign strobe_s  = sync_q[2];

  sr_edge_filter #(.FILT_CYCLES(FILT_CYCLES)) i_filt (
    .clk   (clk),
    .rst   (rst),
    .lvl_i (strobe_s),
    .kick_o(kick)
  );

  sr_watchdog #(.WDT_CYCLES(WDT_CYCLES)) i_wdt (
    .clk   (clk),
    .rst   (rst),
    .hold_i(hold),
    .kick_i(kick),
    .fire_o(wdt_fire),
    .cnt_o (wdt_cnt)
  );

  assign cause = sup_low_s | ~man_n_s | wdt_fire;

  sr_release #(.REL_CYCLES(REL_CYCLES)) i_rel (
    .clk    (clk),
    .rst    (rst),
    .cause_i(cause),
    .hold_o (hold)
  );

  assign rst_n_o = ~hold;

  if (HAS_POS_OUT) begin : g_pos
    assign rst_p_o = hold;
  end else begin : g_nopos
    assign rst_p_o = 1'b0;
  end
endmodule

// File: rtl/sup_reset_ctrl_chk.sv
module sup_reset_ctrl_chk #(
  parameter int REL_CYCLES  = 6554,
  parameter int WDT_CYCLES  = 52429,
  parameter bit HAS_POS_OUT = 1'b1,
  localparam int WW = sr_pkg::cnt_width(WDT_CYCLES),
  localparam int LW = sr_pkg::cnt_width(REL_CYCLES) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          sup_low_s,
  input logic          man_n_s,
  input logic          wdt_fire,
  input logic [WW-1:0] wdt_cnt,
  input logic          rst_n_o,
  input logic          rst_p_o
);
  logic [LW-1:0] low_run_q;
  logic          prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run_q <= '0;
      prev_q    <= 1'b0;
    end else begin
      prev_q <= rst_n_o;
      if (rst_n_o) begin
        low_run_q <= '0;
      end else if (low_run_q != '1) begin
        low_run_q <= low_run_q + 1'b1;
      end
    end
  end

  AST_MIN_PULSE: assert property (@(posedge clk) disable iff (rst)
    (rst_n_o && !prev_q) |-> (low_run_q >= LW'(REL_CYCLES))); // R1
  AST_SUPPLY_HOLD: assert property (@(posedge clk) disable iff (rst)
    sup_low_s |=> !rst_n_o); // R2
  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !man_n_s |=> !rst_n_o); // R3
  AST_WDT_FIRE: assert property (@(posedge clk) disable iff (rst)
    wdt_fire |=> !rst_n_o); // R4
  AST_WDT_CLEARED: assert property (@(posedge clk) disable iff (rst)
    !rst_n_o |=> (wdt_cnt == '0)); // R7

  if (HAS_POS_OUT) begin : g_pos_chk
    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
      rst_p_o == !rst_n_o); // R8
  end else begin : g_nopos_chk
    AST_POS_TIED: assert property (@(posedge clk) disable iff (rst)
      !rst_p_o); // R8
  end
endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk #(
  .REL_CYCLES (REL_CYCLES),
  .WDT_CYCLES (WDT_CYCLES),
  .HAS_POS_OUT(HAS_POS_OUT)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .sup_low_s(sup_low_s),
  .man_n_s  (man_n_s),
  .wdt_fire (wdt_fire),
  .wdt_cnt  (wdt_cnt),
  .rst_n_o  (rst_n_o),
  .rst_p_o  (rst_p_o)
);

// File: tb/test_sup_reset_ctrl.sv
module test_sup_reset_ctrl;
  localparam int REL = 40;
  localparam int WDT = 100;
  localparam int HALF = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sup_low_i = 1'b0;
  logic man_rst_n_i = 1'b1;
  logic wdt_strobe_i = 1'b0;
  logic rst_n_o, rst_p_o;
  logic kick_en = 1'b0;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sup_reset_ctrl #(
    .REL_CYCLES(REL), .WDT_CYCLES(WDT), .FILT_CYCLES(2),
    .SYNC_STAGES(2), .HAS_POS_OUT(1'b1)
  ) i_sup_reset_ctrl (
    .clk(clk), .rst(rst), .sup_low_i(sup_low_i), .man_rst_n_i(man_rst_n_i),
    .wdt_strobe_i(wdt_strobe_i), .rst_n_o(rst_n_o), .rst_p_o(rst_p_o)
  );

  initial begin
    forever begin
      repeat (HALF) @(negedge clk);
      if (kick_en) wdt_strobe_i = ~wdt_strobe_i;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts edges from now until rst_n_o is seen at lvl (sampled at negedge).
  task automatic measure(input logic lvl, output int n);
    n = 0;
    while (n < 5000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (rst_n_o == lvl) break;
    end
  endtask

  task automatic t_power_on;
    int n;
    @(negedge clk);
    check("R1 reset state rst_n_o", int'(rst_n_o), 0);
    check("R8 reset state rst_p_o", int'(rst_p_o), 1);
    kick_en = 1'b1;
    rst = 1'b0;
    measure(1'b1, n);
    check("R1 power-on release cycles", n, REL);
    check("R8 complement after release", int'(rst_p_o), 0);
  endtask

  task automatic t_supply;
    int n;
    sup_low_i = 1'b1;
    measure(1'b0, n);
    check("R2 supply-low assert latency", n, 3);
    repeat (200) @(negedge clk);
    check("R2 held while supply low", int'(rst_n_o), 0);
    sup_low_i = 1'b0;
    measure(1'b1, n);
    check("R2 release after supply return", n, REL + 2);
    sup_low_i = 1'b1;
    repeat (10) @(negedge clk);
    sup_low_i = 1'b0;
    repeat (20) @(negedge clk);
    sup_low_i = 1'b1;
    @(negedge clk);
    sup_low_i = 1'b0;
    measure(1'b1, n);
    check("R2 countdown restart on new event", n, REL + 2);
  endtask

  task automatic t_manual;
    int n;
    man_rst_n_i = 1'b0;
    measure(1'b0, n);
    check("R3 manual assert latency", n, 3);
    repeat (150) @(negedge clk);
    check("R3 held while manual low", int'(rst_n_o), 0);
    check("R8 complement while asserted", int'(rst_p_o), 1);
    man_rst_n_i = 1'b1;
    measure(1'b1, n);
    check("R3 release after manual high", n, REL + 2);
  endtask

  task automatic t_kick_both;
    int lows = 0;
    repeat (700) begin
      @(negedge clk);
      if (!rst_n_o) lows++;
    end
    check("R5 toggling strobe keeps reset released (low cycles)", lows, 0);
  endtask

  task automatic t_stuck;
    int n;
    kick_en = 1'b0;
    man_rst_n_i = 1'b0;
    repeat (20) @(negedge clk);
    man_rst_n_i = 1'b1;
    measure(1'b1, n);
    measure(1'b0, n);
    check("R4 timeout from release", n, WDT);
    measure(1'b1, n);
    check("R4 watchdog reset width", n, REL);
    measure(1'b0, n);
    check("R4 second period high part", n, WDT);
    measure(1'b1, n);
    check("R4 second period low part", n, REL);
  endtask

  task automatic t_hold_clear;
    int n;
    man_rst_n_i = 1'b0;
    repeat (3 * WDT) @(negedge clk);
    man_rst_n_i = 1'b1;
    measure(1'b1, n);
    check("R7 release after long manual reset", n, REL + 2);
    measure(1'b0, n);
    check("R7 full timeout after long reset", n, WDT);
    measure(1'b1, n);
  endtask

  task automatic t_glitch;
    int n;
    logic base;
    base = wdt_strobe_i;
    man_rst_n_i = 1'b0;
    repeat (10) @(negedge clk);
    man_rst_n_i = 1'b1;
    measure(1'b1, n);
    n = 0;
    while (rst_n_o && n < 500) begin
      repeat (9) begin
        @(negedge clk);
        n++;
        if (!rst_n_o) break;
      end
      if (!rst_n_o) break;
      wdt_strobe_i = ~base;
      @(negedge clk);
      n++;
      wdt_strobe_i = base;
    end
    check("R6 glitches ignored, timeout unchanged", n, WDT);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_power_on();
    t_supply();
    t_manual();
    t_kick_both();
    t_stuck();
    t_hold_clear();
    t_glitch();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule